// File: doc/BRIEF.md
# Hierarchical Device Interrupt Register Block

This block is the interrupt front end of a bus-attached peripheral. It has two cascaded levels. The IP level latches rising edges from the peripheral's event inputs into a status word. Software can toggle that word and mask it bit by bit. The IP level folds its enabled bits into one summary source.

The device level builds a 32-bit status word from four kinds of bit. Bit 0 is a latched internal error bit. Bit 1 is unused and reads 0. Bit 2 carries the IP-level summary. Bits 3 to 31 follow live sources from internal sub-blocks. The device level then applies a per-bit enable mask and exposes the masked pending word. A priority encoder returns the lowest pending bit index. A single global enable gates the one interrupt output.

Software reaches the block through a single-cycle register port. A write takes effect at the clock edge on which `wr_i` is high. `rdata_o` is a combinational view of the register selected by `addr_i`. Writing the key value to the reset register returns the whole block to its reset state.

Top module: `dev_irq_regs`

## Requirements
- R1: Byte offsets are decoded exactly: device status 0, device pending 4, device enable 8, interrupt ID 24, global enable 28, IP status 32, IP enable 40, reset 64. Every other offset reads 0 and ignores writes. The reset register reads 0.
- R2: Device pending reads device status AND device enable, combinationally, and is read-only.
- R3: The interrupt ID register returns the lowest-numbered set bit of device pending (0..31), so bit 0 has the highest priority. It returns 128 when pending is zero, and it is read-only.
- R4: `irq_o` is 1 exactly when global enable bit 31 is 1 and device pending is nonzero. The global enable register stores only bit 31; all its other bits read 0.
- R5: Device status bit 0 is a latched error bit. A write with data bit 0 = 1 inverts it, and a write with data bit 0 = 0 leaves it unchanged. A cycle with `err_set_i` high sets it, and that set wins over a simultaneous inverting write.
- R6: Device status bit 2 equals the OR of (IP status AND IP enable). Bits 31:3 equal `sub_live_i[28:0]`, and bit 1 reads 0. Writes to bits 31:1 of device status have no effect.
- R7: Each IP status bit inverts when written with 1 and is unchanged when written with 0. Bits at index IP_N and above read 0.
- R8: A rising edge on `ip_evt_i[k]` sets IP status bit k. A set that coincides with an inverting write on the same bit wins. A level held high does not set the bit again after software clears it.
- R9: Writing 32'h0000000A to offset 64 zeroes every status, enable and global-enable register on the next edge. Writing any other value there has no effect.
- R10: After `rst_ni` the status, enable and global-enable registers are zero, the ID register reads 128 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ip_evt_i | input | IP_N | IP event inputs, rising-edge sensitive |
| err_set_i | input | 1 | Sets the internal error status bit |
| sub_live_i | input | 29 | Live sub-block sources for device status bits 31:3 |
| irq_o | output | 1 | Device interrupt output |

## Verification
The assertions assume that `err_set_i`, `ip_evt_i` and `sub_live_i` are synchronous to `clk_i`. They also assume that a write and its address are stable around the edge that samples them. The bench keeps to this by changing every input only on the falling edge, and it holds each write for exactly one rising edge. Collisions between a hardware set and a software toggle are created on purpose in the same cycle. In those cases the set is expected to win, so the toggle checks are only asserted for cycles with no coincident set.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int DW       = 32;
  localparam int AW       = 7;
  localparam int ERR_BIT  = 0;
  localparam int AGG_BIT  = 2;
  localparam int LIVE_LO  = 3;
  localparam int LIVE_N   = DW - LIVE_LO;
  localparam int GIE_BIT  = DW - 1;

  localparam logic [AW-1:0] OFF_DSTAT = 7'd0;
  localparam logic [AW-1:0] OFF_DPEND = 7'd4;
  localparam logic [AW-1:0] OFF_DEN   = 7'd8;
  localparam logic [AW-1:0] OFF_DID   = 7'd24;
  localparam logic [AW-1:0] OFF_GIE   = 7'd28;
  localparam logic [AW-1:0] OFF_ISTAT = 7'd32;
  localparam logic [AW-1:0] OFF_IEN   = 7'd40;
  localparam logic [AW-1:0] OFF_RST   = 7'd64;

  localparam logic [DW-1:0] RST_KEY   = 32'h0000_000A;
  localparam logic [DW-1:0] NO_IRQ_ID = 32'd128;
endpackage

// File: rtl/ip_irq_level.sv
module ip_irq_level #(
  parameter int IP_N = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [IP_N-1:0] evt_i,
  input  logic            st_we_i,
  input  logic            en_we_i,
  input  logic [IP_N-1:0] wdata_i,
  output logic [IP_N-1:0] status_o,
  output logic [IP_N-1:0] enable_o,
  output logic            agg_o
);
  logic [IP_N-1:0] evt_q, rise, tgl;

  assign rise = evt_i & ~evt_q;
  assign tgl  = st_we_i ? wdata_i : '0;

  // edge tracker is not cleared by soft reset, so a held level cannot retrigger
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     status_o <= '0;
    else if (clr_i)  status_o <= '0;
    else             status_o <= (status_o ^ tgl) | rise;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      enable_o <= '0;
    else if (clr_i)   enable_o <= '0;
    else if (en_we_i) enable_o <= wdata_i;

  assign agg_o = |(status_o & enable_o);

  a_r7_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !clr_i && rise == '0) |=> status_o == $past(status_o ^ wdata_i));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0 && !clr_i) |=> (status_o & $past(rise)) == $past(rise));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_we_i && !clr_i && rise == '0) |=> $stable(status_o));
endmodule

// File: rtl/dev_irq_level.sv
module dev_irq_level
  import dirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              err_set_i,
  input  logic              ip_agg_i,
  input  logic [LIVE_N-1:0] live_i,
  input  logic              st_we_i,
  input  logic              en_we_i,
  input  logic              gie_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     status_o,
  output logic [DW-1:0]     pending_o,
  output logic [DW-1:0]     enable_o,
  output logic              gie_o,
  output logic [DW-1:0]     id_o,
  output logic              irq_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        err_q <= 1'b0;
    else if (clr_i)     err_q <= 1'b0;
    else if (err_set_i) err_q <= 1'b1;
    else if (st_we_i)   err_q <= err_q ^ wdata_i[ERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      enable_o <= '0;
    else if (clr_i)   enable_o <= '0;
    else if (en_we_i) enable_o <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       gie_o <= 1'b0;
    else if (clr_i)    gie_o <= 1'b0;
    else if (gie_we_i) gie_o <= wdata_i[GIE_BIT];

  assign status_o  = {live_i, ip_agg_i, 1'b0, err_q};
  assign pending_o = status_o & enable_o;

  // lowest index wins: scan from the top so later hits overwrite
  always_comb begin
    id_o = NO_IRQ_ID;
    for (int i = DW - 1; i >= 0; i--)
      if (pending_o[i]) id_o = DW'(i);
  end

  assign irq_o = gie_o & (|pending_o);

  a_r5_err_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i && !clr_i) |=> status_o[ERR_BIT]);

  a_r5_err_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !err_set_i && !clr_i) |=> status_o[ERR_BIT] == $past(status_o[ERR_BIT] ^ wdata_i[ERR_BIT]));

  a_r3_id_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o == '0) == (id_o == NO_IRQ_ID));

  a_r3_id_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o != NO_IRQ_ID) |-> (pending_o[id_o[4:0]] &&
      ((pending_o & ((DW'(1) << id_o[4:0]) - DW'(1))) == '0)));
endmodule

// File: rtl/dev_irq_regs.sv
module dev_irq_regs
  import dirq_pkg::*;
#(
  parameter int IP_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [IP_N-1:0]   ip_evt_i,
  input  logic              err_set_i,
  input  logic [LIVE_N-1:0] sub_live_i,
  output logic              irq_o
);
  logic            swrst;
  logic            ist_we, ien_we, dst_we, den_we, gie_we;
  logic [IP_N-1:0] ip_st, ip_en;
  logic            ip_agg;
  logic [DW-1:0]   d_st, d_pend, d_en, d_id;
  logic            d_gie;

  assign swrst  = wr_i && addr_i == OFF_RST && wdata_i == RST_KEY;
  assign ist_we = wr_i && addr_i == OFF_ISTAT;
  assign ien_we = wr_i && addr_i == OFF_IEN;
  assign dst_we = wr_i && addr_i == OFF_DSTAT;
  assign den_we = wr_i && addr_i == OFF_DEN;
  assign gie_we = wr_i && addr_i == OFF_GIE;

  ip_irq_level #(.IP_N(IP_N)) u_ip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (swrst),
    .evt_i    (ip_evt_i),
    .st_we_i  (ist_we),
    .en_we_i  (ien_we),
    .wdata_i  (wdata_i[IP_N-1:0]),
    .status_o (ip_st),
    .enable_o (ip_en),
    .agg_o    (ip_agg)
  );

  dev_irq_level u_dev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (swrst),
    .err_set_i (err_set_i),
    .ip_agg_i  (ip_agg),
    .live_i    (sub_live_i),
    .st_we_i   (dst_we),
    .en_we_i   (den_we),
    .gie_we_i  (gie_we),
    .wdata_i   (wdata_i),
    .status_o  (d_st),
    .pending_o (d_pend),
    .enable_o  (d_en),
    .gie_o     (d_gie),
    .id_o      (d_id),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_DSTAT: rdata_o = d_st;
      OFF_DPEND: rdata_o = d_pend;
      OFF_DEN:   rdata_o = d_en;
      OFF_DID:   rdata_o = d_id;
      OFF_GIE:   rdata_o[GIE_BIT] = d_gie;
      OFF_ISTAT: rdata_o[IP_N-1:0] = ip_st;
      OFF_IEN:   rdata_o[IP_N-1:0] = ip_en;
      default:   rdata_o = '0;
    endcase
  end

  a_r4_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (d_gie && (d_st & d_en) != '0));

  a_r6_agg_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_st[AGG_BIT] == |(ip_st & ip_en));

  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> (ip_st == '0 && ip_en == '0 && d_en == '0 && !d_gie && !d_st[ERR_BIT]));
endmodule

// File: tb/dev_irq_regs_bench.sv
module dev_irq_regs_bench;
  localparam int IP_N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [IP_N-1:0] ip_evt = '0;
  logic        err_set = 1'b0;
  logic [28:0] live = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dev_irq_regs #(.IP_N(IP_N)) u_dev_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ip_evt_i(ip_evt), .err_set_i(err_set),
    .sub_live_i(live), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [6:0]  wa;
    logic [31:0] wd;
    logic [28:0] live;
    logic [6:0]  ra;
    logic [31:0] exp;
    logic        irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'd0,  32'h0,        29'h0,       7'd24, 32'd128,      1'b0, 8'd10}, // R10
    '{1'b1, 7'd8,  32'hFFFFFFFF, 29'h0,       7'd8,  32'hFFFFFFFF, 1'b0, 8'd1},  // R1
    '{1'b1, 7'd0,  32'h1,        29'h0,       7'd4,  32'h1,        1'b0, 8'd5},  // R5 R2
    '{1'b1, 7'd28, 32'h80000000, 29'h0,       7'd28, 32'h80000000, 1'b1, 8'd4},  // R4
    '{1'b0, 7'd0,  32'h0,        29'h10,      7'd0,  32'h81,       1'b1, 8'd6},  // R6
    '{1'b1, 7'd0,  32'hFFFFFFFE, 29'h10,      7'd0,  32'h81,       1'b1, 8'd6},  // R6
    '{1'b1, 7'd0,  32'h1,        29'h10,      7'd24, 32'd7,        1'b1, 8'd3},  // R3
    '{1'b1, 7'd8,  32'h70,       29'h10,      7'd24, 32'd128,      1'b0, 8'd2},  // R2
    '{1'b1, 7'd8,  32'hFFFFFF00, 29'h100010,  7'd24, 32'd23,       1'b1, 8'd3},  // R3
    '{1'b1, 7'd12, 32'hFFFFFFFF, 29'h100010,  7'd12, 32'h0,        1'b1, 8'd1},  // R1
    '{1'b1, 7'd28, 32'h7FFFFFFF, 29'h100010,  7'd28, 32'h0,        1'b0, 8'd4},  // R4
    '{1'b1, 7'd40, 32'hFFFFFFFF, 29'h0,       7'd40, 32'hFF,       1'b0, 8'd7},  // R7
    '{1'b1, 7'd32, 32'h05,       29'h0,       7'd0,  32'h4,        1'b0, 8'd6},  // R6
    '{1'b1, 7'd28, 32'h80000000, 29'h0,       7'd24, 32'd128,      1'b0, 8'd2},  // R2
    '{1'b1, 7'd8,  32'h4,        29'h0,       7'd24, 32'd2,        1'b1, 8'd3},  // R3
    '{1'b1, 7'd32, 32'h04,       29'h0,       7'd32, 32'h1,        1'b1, 8'd7},  // R7
    '{1'b1, 7'd40, 32'h02,       29'h0,       7'd4,  32'h0,        1'b0, 8'd6},  // R6
    '{1'b1, 7'd64, 32'h5,        29'h0,       7'd40, 32'h2,        1'b0, 8'd9},  // R9
    '{1'b1, 7'd64, 32'hA,        29'h0,       7'd28, 32'h0,        1'b0, 8'd9}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd_chk("R10 dstat", 7'd0, 32'h0);
    rd_chk("R10 id", 7'd24, 32'd128);
    chk("R10 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      live = VEC[i].live;
      if (VEC[i].wr) wr_reg(VEC[i].wa, VEC[i].wd);
      rd_chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), VEC[i].ra, VEC[i].exp);
      chk($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].irq});
    end

    // R9 everything cleared by key write
    rd_chk("R9 den", 7'd8, 32'h0);
    rd_chk("R9 ien", 7'd40, 32'h0);
    rd_chk("R9 istat", 7'd32, 32'h0);
    rd_chk("R9 dstat", 7'd0, 32'h0);
    rd_chk("R9 id", 7'd24, 32'd128);
    rd_chk("R1 rst reads 0", 7'd64, 32'h0);
    wr_reg(7'd2, 32'hFFFFFFFF);
    rd_chk("R1 unaligned reserved", 7'd2, 32'h0);

    // R8 edge capture
    wr_reg(7'd40, 32'h1);
    wr_reg(7'd8, 32'h4);
    wr_reg(7'd28, 32'h80000000);
    @(negedge clk); ip_evt = 8'h01;
    @(negedge clk);
    rd_chk("R8 edge sets", 7'd32, 32'h1);
    chk("R8 irq", {31'b0, irq}, 32'h1);
    wr_reg(7'd32, 32'h1);
    @(negedge clk);
    rd_chk("R8 held level no reset", 7'd32, 32'h0);
    chk("R8 irq clear", {31'b0, irq}, 32'h0);
    ip_evt = 8'h00;
    @(negedge clk);
    wr_reg(7'd32, 32'h1);
    rd_chk("R7 toggle on", 7'd32, 32'h1);
    @(negedge clk);
    wr = 1'b1; addr = 7'd32; wdata = 32'h1; ip_evt = 8'h01;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    rd_chk("R8 set beats toggle", 7'd32, 32'h1);
    ip_evt = 8'h00;

    // R5 error bit
    wr_reg(7'd8, 32'h1);
    @(negedge clk); err_set = 1'b1;
    @(negedge clk); err_set = 1'b0;
    rd_chk("R5 err set id", 7'd24, 32'd0);
    @(negedge clk);
    wr = 1'b1; addr = 7'd0; wdata = 32'h1; err_set = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0; err_set = 1'b0;
    rd_chk("R5 set beats toggle", 7'd4, 32'h1);
    wr_reg(7'd0, 32'h1);
    rd_chk("R5 toggle clears", 7'd4, 32'h0);
    chk("R5 irq off", {31'b0, irq}, 32'h0);

    // R3 priority across sources
    wr_reg(7'd8, 32'hFFFFFFFF);
    live = 29'h1FFFFFFF;
    rd_chk("R3 agg beats live", 7'd24, 32'd2);
    rd_chk("R6 full status", 7'd0, 32'hFFFFFFFC);
    live = 29'h10000000;
    wr_reg(7'd32, 32'h1);
    rd_chk("R3 top bit", 7'd24, 32'd31);
    chk("R4 irq top", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule